// File: doc/BRIEF.md
# Boundary-Scan Test Program Sequencer

This block runs a board-level boundary-scan test by stepping through a small program held in an external read-only memory. Each program word is decoded in the cycle it is addressed. The word can produce TAP clock activity, hand a scan operation to the built-in shift engine, change the active scan chain, talk to outside test equipment over a one-bit handshake, or change the program flow. The TAP clock is produced as a one-cycle strobe, `tck_pulse`. Each strobe stands for one TCK period, with `tms` and `tdi` valid for that cycle, and `tdo` is sampled at the end of that same cycle.

A scan compare checks the bits shifted out of the chain against expected values under a mask. Any mismatch raises a sticky error flag, chosen earlier by a separate instruction. Later in the program, a jump can test that flag. The program stops at an end word. The sequencer then shows a halted status together with the final error flags, and it stays there until the next reset.

Top module: `bscan_seq`

## Requirements
- R1: While reset is asserted, and until the program runs, `halted` is 0, `err_flags` is 0, `tck_pulse` is 0, `sync_out` is 0 and `imem_addr` is 0.
- R2: A program word is 16 bits. The opcode is in bits [15:12] and the operand is in bits [11:0]. The opcodes are: 0 end, 1 single clock, 2 load count, 3 run count, 4 chain select, 5 set sync output, 6 wait sync input, 7 flag select, 8 conditional jump, 9 shift, A shift-and-compare.
- R3: Opcode 1 produces exactly one `tck_pulse` cycle, with `tms` equal to operand bit 0.
- R4: Opcode 2 stores the operand bits [11:0] as count N. Opcode 3 produces N consecutive pulses with `tms` at 0, and N = 0 produces no pulse. N is kept after use, so a second run repeats it.
- R5: Opcode 9 uses operand bits [3:0] as the length minus one (L = 1..16), and takes the next word as the vector. It produces L pulses, least significant bit first, with `tdi` equal to vector bit i on pulse i. `tms` is 0 on every pulse except the last one, where it is 1.
- R6: Opcode A is followed by three words: the vector, the expected value and the mask. On pulse i, if mask bit i is 1 and the `tdo` seen during that pulse differs from expected bit i, the selected error flag is set. Mismatches under mask bits that are 0 set no flag.
- R7: Opcode 7 selects the flag with operand bits [1:0]. Error flags only ever go from 0 to 1, and they clear only on reset.
- R8: Opcode 4 drives `chain_sel` from operand bits [1:0] and holds it there.
- R9: Opcode 5 drives `sync_out` to operand bit 0 and holds it there.
- R10: Opcode 6 stalls the program with no pulses and a steady `imem_addr` until `sync_in`, after a two-flop synchroniser, equals operand bit 0. At least two clock edges pass between a change of `sync_in` and the release of the stall.
- R11: Opcode 8 jumps to operand bits [7:0] when the selected flag equals operand bit 11. Otherwise it moves to the next word.
- R12: Opcode 0 sets `halted`. From then on there are no pulses, `imem_addr` stays frozen, and `err_flags` keeps its final value.
- R13: Opcodes B to F advance to the next word and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Program word address |
| imem_data | input | 16 | Program word read at `imem_addr` in the same cycle |
| tck_pulse | output | 1 | One TAP clock period for each high cycle |
| tms | output | 1 | TMS level for the current pulse |
| tdi | output | 1 | TDI level for the current pulse |
| tdo | input | 1 | TDO level, sampled at the end of a pulse cycle |
| chain_sel | output | 2 | Active scan chain |
| sync_out | output | 1 | Handshake output to test equipment |
| sync_in | input | 1 | Handshake input from test equipment (asynchronous) |
| halted | output | 1 | Program has reached its end word |
| err_flags | output | 4 | Sticky compare error flags |

## Verification
The assertions check the properties that hold on every cycle. Once `halted` is set it stays set, with no pulses and a frozen address. Error flags never fall, and at most one flag rises in any cycle. The chain selection cannot change between back-to-back pulses. The directed scenarios cover the behaviour that depends on the program: pulse counts and `tms` shapes, the order of the shifted bits, the effect of masked and unmasked compare mismatches, both jump polarities, the synchroniser delay on the handshake wait, and undefined opcodes acting as no-ops.

// File: rtl/bscan_seq_pkg.sv
package bscan_seq_pkg;

  localparam logic [3:0] OP_END   = 4'h0;
  localparam logic [3:0] OP_TCLK  = 4'h1;
  localparam logic [3:0] OP_LDCNT = 4'h2;
  localparam logic [3:0] OP_RUN   = 4'h3;
  localparam logic [3:0] OP_CHAIN = 4'h4;
  localparam logic [3:0] OP_SOUT  = 4'h5;
  localparam logic [3:0] OP_WAIT  = 4'h6;
  localparam logic [3:0] OP_ESEL  = 4'h7;
  localparam logic [3:0] OP_JMPF  = 4'h8;
  localparam logic [3:0] OP_SHIFT = 4'h9;
  localparam logic [3:0] OP_SHCHK = 4'hA;

  typedef enum logic [3:0] {
    ST_EXEC, ST_TCK, ST_RUN, ST_WAIT,
    ST_LDV, ST_LDE, ST_LDM, ST_SHF, ST_HALT
  } seq_state_e;

endpackage

// File: rtl/bscan_sync2.sv
module bscan_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/bscan_shift_eng.sv
module bscan_shift_eng #(
  parameter int DW = 16,
  localparam int LENW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   word,
  input  logic            ld_vec,
  input  logic            ld_exp,
  input  logic            ld_msk,
  input  logic            clr_msk,
  input  logic            go,
  input  logic [LENW-1:0] len,
  input  logic            tdo,
  output logic            active,
  output logic            tms,
  output logic            tdi,
  output logic            last,
  output logic            miss
);
  logic [DW-1:0]   vec_q, vec_d, exp_q, exp_d, msk_q, msk_d;
  logic [LENW-1:0] idx_q, idx_d, len_q, len_d;
  logic            act_q, act_d;

  assign active = act_q;
  assign last   = act_q && (idx_q == len_q);
  assign tms    = last;
  assign tdi    = act_q && vec_q[idx_q];
  assign miss   = act_q && msk_q[idx_q] && (tdo != exp_q[idx_q]);

  always_comb begin
    vec_d = vec_q;
    exp_d = exp_q;
    msk_d = msk_q;
    idx_d = idx_q;
    len_d = len_q;
    act_d = act_q;
    if (ld_vec)  vec_d = word;
    if (ld_exp)  exp_d = word;
    if (ld_msk)  msk_d = word;
    if (clr_msk) msk_d = '0;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
      len_d = len;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      exp_q <= '0;
      msk_q <= '0;
      idx_q <= '0;
      len_q <= '0;
      act_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      exp_q <= exp_d;
      msk_q <= msk_d;
      idx_q <= idx_d;
      len_q <= len_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/bscan_seq.sv
module bscan_seq
  import bscan_seq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int NCHAIN = 4,
  parameter int NFLAG  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [AW-1:0]             imem_addr,
  input  logic [DW-1:0]             imem_data,
  output logic                      tck_pulse,
  output logic                      tms,
  output logic                      tdi,
  input  logic                      tdo,
  output logic [$clog2(NCHAIN)-1:0] chain_sel,
  output logic                      sync_out,
  input  logic                      sync_in,
  output logic                      halted,
  output logic [NFLAG-1:0]          err_flags
);
  localparam int OPW  = 4;
  localparam int ARGW = DW - OPW;
  localparam int LENW = $clog2(DW);
  localparam int CHW  = $clog2(NCHAIN);
  localparam int FLW  = $clog2(NFLAG);

  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  logic sync_s;
  bscan_sync2 #(.W(1)) sync_i (
    .clk(clk), .rst_n(rst_s_n), .d(sync_in), .q(sync_s)
  );

  seq_state_e      state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic [ARGW-1:0] cnt_q, cnt_d, work_q, work_d;
  logic [CHW-1:0]  chain_q, chain_d;
  logic [FLW-1:0]  esel_q, esel_d;
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [LENW-1:0] shlen_q, shlen_d;
  logic            sout_q, sout_d, wlvl_q, wlvl_d;
  logic            ktms_q, ktms_d, shchk_q, shchk_d;

  logic [OPW-1:0]  op;
  logic [ARGW-1:0] arg;
  assign op  = imem_data[DW-1 -: OPW];
  assign arg = imem_data[ARGW-1:0];

  logic ld_vec, ld_exp, ld_msk, clr_msk, go;
  logic eng_act, eng_tms, eng_tdi, eng_last, eng_miss;

  bscan_shift_eng #(.DW(DW)) eng_i (
    .clk(clk), .rst_n(rst_s_n), .word(imem_data),
    .ld_vec(ld_vec), .ld_exp(ld_exp), .ld_msk(ld_msk), .clr_msk(clr_msk),
    .go(go), .len(shlen_q), .tdo(tdo),
    .active(eng_act), .tms(eng_tms), .tdi(eng_tdi),
    .last(eng_last), .miss(eng_miss)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    cnt_d   = cnt_q;
    work_d  = work_q;
    chain_d = chain_q;
    esel_d  = esel_q;
    flags_d = flags_q;
    shlen_d = shlen_q;
    sout_d  = sout_q;
    wlvl_d  = wlvl_q;
    ktms_d  = ktms_q;
    shchk_d = shchk_q;
    ld_vec  = 1'b0;
    ld_exp  = 1'b0;
    ld_msk  = 1'b0;
    clr_msk = 1'b0;
    go      = 1'b0;
    if (eng_miss) flags_d[esel_q] = 1'b1;
    unique case (state_q)
      ST_EXEC: begin
        pc_d = pc_q + 1'b1;
        case (op)
          OP_END:   begin pc_d = pc_q; state_d = ST_HALT; end
          OP_TCLK:  begin ktms_d = arg[0]; state_d = ST_TCK; end
          OP_LDCNT: cnt_d = arg;
          OP_RUN:   if (cnt_q != '0) begin work_d = cnt_q; state_d = ST_RUN; end
          OP_CHAIN: chain_d = arg[CHW-1:0];
          OP_SOUT:  sout_d = arg[0];
          OP_WAIT:  begin wlvl_d = arg[0]; state_d = ST_WAIT; end
          OP_ESEL:  esel_d = arg[FLW-1:0];
          OP_JMPF:  if (flags_q[esel_q] == arg[ARGW-1]) pc_d = arg[AW-1:0];
          OP_SHIFT, OP_SHCHK: begin
            shlen_d = arg[LENW-1:0];
            shchk_d = (op == OP_SHCHK);
            state_d = ST_LDV;
          end
          default: ;
        endcase
      end
      ST_TCK:  state_d = ST_EXEC;
      ST_RUN: begin
        work_d = work_q - 1'b1;
        if (work_q == ARGW'(1)) state_d = ST_EXEC;
      end
      ST_WAIT: if (sync_s == wlvl_q) state_d = ST_EXEC;
      ST_LDV: begin
        ld_vec = 1'b1;
        pc_d   = pc_q + 1'b1;
        if (shchk_q) state_d = ST_LDE;
        else begin clr_msk = 1'b1; go = 1'b1; state_d = ST_SHF; end
      end
      ST_LDE: begin ld_exp = 1'b1; pc_d = pc_q + 1'b1; state_d = ST_LDM; end
      ST_LDM: begin ld_msk = 1'b1; go = 1'b1; pc_d = pc_q + 1'b1; state_d = ST_SHF; end
      ST_SHF:  if (eng_last) state_d = ST_EXEC;
      ST_HALT: ;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_EXEC;
      pc_q    <= '0;
      cnt_q   <= '0;
      work_q  <= '0;
      chain_q <= '0;
      esel_q  <= '0;
      flags_q <= '0;
      shlen_q <= '0;
      sout_q  <= 1'b0;
      wlvl_q  <= 1'b0;
      ktms_q  <= 1'b0;
      shchk_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      cnt_q   <= cnt_d;
      work_q  <= work_d;
      chain_q <= chain_d;
      esel_q  <= esel_d;
      flags_q <= flags_d;
      shlen_q <= shlen_d;
      sout_q  <= sout_d;
      wlvl_q  <= wlvl_d;
      ktms_q  <= ktms_d;
      shchk_q <= shchk_d;
    end
  end

  assign imem_addr = pc_q;
  assign tck_pulse = (state_q == ST_TCK) || (state_q == ST_RUN) || eng_act;
  assign tms       = (state_q == ST_TCK) ? ktms_q : eng_tms;
  assign tdi       = eng_tdi;
  assign chain_sel = chain_q;
  assign sync_out  = sout_q;
  assign halted    = (state_q == ST_HALT);
  assign err_flags = flags_q;
endmodule

// File: rtl/bscan_seq_chk.sv
module bscan_seq_chk #(
  parameter int AW     = 8,
  parameter int NCHAIN = 4,
  parameter int NFLAG  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW-1:0]             imem_addr,
  input logic                      tck_pulse,
  input logic [$clog2(NCHAIN)-1:0] chain_sel,
  input logic                      halted,
  input logic [NFLAG-1:0]          err_flags
);
  // R12
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R12
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tck_pulse);
  // R12
  halted_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr));
  // R7
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |=> (($past(err_flags) & ~err_flags) == '0));
  // R7
  one_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(err_flags & ~$past(err_flags)) <= 1);
  // R8
  chain_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_pulse && $past(tck_pulse)) |-> $stable(chain_sel));
endmodule

bind bscan_seq bscan_seq_chk #(.AW(AW), .NCHAIN(NCHAIN), .NFLAG(NFLAG)) chk_i (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .tck_pulse(tck_pulse),
  .chain_sel(chain_sel), .halted(halted), .err_flags(err_flags)
);

// File: tb/bscan_seq_tb_top.sv
`timescale 1ns/1ps
module bscan_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic        tck_pulse, tms, tdi, tdo;
  logic [1:0]  chain_sel;
  logic        sync_out, sync_in, halted;
  logic [3:0]  err_flags;

  logic [15:0] rom [0:255];
  logic [15:0] chain_reg, chain_init;
  logic        tms_log [0:63];
  logic        tdi_log [0:63];
  int          n_pulse;
  int          chk_cnt = 0;
  int          fail_cnt = 0;

  always #2.5 clk = ~clk;

  bscan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .tck_pulse(tck_pulse), .tms(tms), .tdi(tdi), .tdo(tdo),
    .chain_sel(chain_sel), .sync_out(sync_out), .sync_in(sync_in),
    .halted(halted), .err_flags(err_flags)
  );

  assign imem_data = rom[imem_addr];
  assign tdo = chain_reg[0];

  // scan chain model: shifts toward bit 0 on each pulse
  always @(posedge clk) begin
    if (!rst_n) chain_reg <= chain_init;
    else if (tck_pulse) chain_reg <= {tdi, chain_reg[15:1]};
  end

  always @(negedge clk) begin
    if (!rst_n) n_pulse = 0;
    else if (tck_pulse) begin
      if (n_pulse < 64) begin
        tms_log[n_pulse] = tms;
        tdi_log[n_pulse] = tdi;
      end
      n_pulse = n_pulse + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_clear();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
  endtask

  task automatic start_prog(input logic [15:0] chain_start);
    chain_init = chain_start;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
  endtask

  function automatic int tms_ones();
    int c = 0;
    for (int i = 0; i < 64 && i < n_pulse; i++) c += int'(tms_log[i]);
    return c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    chain_init = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 halted", 32'(halted), 0);
    check("R1 err_flags", 32'(err_flags), 0);
    check("R1 tck_pulse", 32'(tck_pulse), 0);
    check("R1 sync_out", 32'(sync_out), 0);
    check("R1 imem_addr", 32'(imem_addr), 0);
  endtask

  task automatic t_clk_run();
    load_clear();
    rom[0] = 16'h1001; rom[1] = 16'h1000; rom[2] = 16'h2005; rom[3] = 16'h3000;
    rom[4] = 16'h3000; rom[5] = 16'h2000; rom[6] = 16'h3000; rom[7] = 16'h0000;
    start_prog(16'h0);
    wait_halt();
    check("R4 pulse count", 32'(n_pulse), 12);
    check("R3 first tms", 32'(tms_log[0]), 1);
    check("R3 second tms", 32'(tms_log[1]), 0);
    check("R4 tms low in runs", 32'(tms_ones()), 1);
    check("R2 halted at end word", 32'(imem_addr), 7);
    repeat (10) @(negedge clk);
    check("R12 no pulses after end", 32'(n_pulse), 12);
    check("R12 halted held", 32'(halted), 1);
    check("R12 address frozen", 32'(imem_addr), 7);
  endtask

  task automatic t_shift();
    load_clear();
    rom[0] = 16'h4002; rom[1] = 16'h9007; rom[2] = 16'h00A5; rom[3] = 16'h0000;
    start_prog(16'h0);
    wait_halt();
    check("R5 pulse count", 32'(n_pulse), 8);
    for (int i = 0; i < 8; i++) check("R5 tdi order", 32'(tdi_log[i]), 32'((8'hA5 >> i) & 1));
    check("R5 tms only last", 32'(tms_ones()), 1);
    check("R5 tms on last", 32'(tms_log[7]), 1);
    check("R5 chain contents", 32'(chain_reg[15:8]), 32'h00A5);
    check("R8 chain_sel", 32'(chain_sel), 2);
    check("R5 no flags", 32'(err_flags), 0);
  endtask

  task automatic t_check_pass();
    load_clear();
    rom[0] = 16'h7001; rom[1] = 16'hA00F; rom[2] = 16'h1234; rom[3] = 16'h1234;
    rom[4] = 16'hFFFF; rom[5] = 16'h8009; rom[6] = 16'h0000;
    rom[9] = 16'h5001; rom[10] = 16'h0000;
    start_prog(16'h1234);
    wait_halt();
    check("R6 matching compare leaves flags", 32'(err_flags), 0);
    check("R6 pulse count", 32'(n_pulse), 16);
    check("R11 jump on clear flag taken", 32'(imem_addr), 10);
    check("R9 sync_out set", 32'(sync_out), 1);
    check("R6 chain restored", 32'(chain_reg), 32'h1234);
  endtask

  task automatic t_check_fail();
    load_clear();
    rom[0] = 16'h7002;
    rom[1] = 16'hA00F; rom[2] = 16'h1234; rom[3] = 16'h1235; rom[4] = 16'hFFFE;
    rom[5] = 16'h881E;
    rom[6] = 16'hA00F; rom[7] = 16'h1234; rom[8] = 16'h1230; rom[9] = 16'h000F;
    rom[10] = 16'h8814; rom[11] = 16'h1001; rom[12] = 16'h0000;
    rom[20] = 16'h5001; rom[21] = 16'h0000; rom[30] = 16'h0000;
    start_prog(16'h1234);
    wait_halt();
    check("R6 masked mismatch ignored, R7 selected flag set", 32'(err_flags), 32'h4);
    check("R11 jump on set flag taken", 32'(imem_addr), 21);
    check("R11 no fall-through pulse", 32'(n_pulse), 32);
    check("R9 sync_out after jump", 32'(sync_out), 1);
    repeat (5) @(negedge clk);
    check("R12 final flags held", 32'(err_flags), 32'h4);
  endtask

  task automatic t_wait();
    load_clear();
    rom[0] = 16'h5001; rom[1] = 16'h6001; rom[2] = 16'hF123;
    rom[3] = 16'h1000; rom[4] = 16'h0000;
    sync_in = 1'b0;
    start_prog(16'h0);
    repeat (30) @(negedge clk);
    check("R10 stalled not halted", 32'(halted), 0);
    check("R10 no pulses while waiting", 32'(n_pulse), 0);
    check("R10 address steady", 32'(imem_addr), 2);
    check("R9 sync_out level", 32'(sync_out), 1);
    sync_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 synchroniser delay", 32'(imem_addr), 2);
    wait_halt();
    check("R13 undefined opcode skipped", 32'(imem_addr), 4);
    check("R13 single pulse only", 32'(n_pulse), 1);
    check("R3 tms low", 32'(tms_log[0]), 0);
    sync_in = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    sync_in = 1'b0;
    chain_init = 16'h0;
    load_clear();
    t_reset();
    t_clk_run();
    t_shift();
    t_check_pass();
    t_check_fail();
    t_wait();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule